// File: doc/BRIEF.md
# Accumulator Processor with Index Register

This block is a compact multi-cycle processor built around a single 16-bit accumulator, a 9-bit index register and a 9-bit program counter. Code and data share one word-addressed memory that sits outside the block. The memory has one port, reads with one cycle of latency and writes synchronously. Each instruction walks a fixed control sequence: fetch, decode, an optional pointer read, an optional operand read, execute, and an optional write-back. A simple operation therefore takes three cycles. A fully indirect read-modify-write takes seven.

The operand address can be offset by the index register, can be replaced by a pointer read from memory, or both. Indexing is applied first and the pointer read second. A dedicated branch tests the index register and, when the test fails, steps it by one in the same instruction, so a counting loop needs no separate bookkeeping. A subroutine call parks its return address in the first word of the callee, and the callee returns through an indirect jump. A halt instruction freezes the core, and the core stays frozen until reset.

Top module: `acc_core`

## Requirements
- R1: A synchronous active-high reset clears PC, AC and IX and deasserts `halted`. In the first cycle after reset, the core reads address 0 with `mem_we` low.
- R2: Instruction fields: opcode in bits [15:11], index-select in bit [10], indirect in bit [9], address field in bits [8:0]. Opcodes: 0 HLT, 1 LOAD, 2 STORE, 3 ADD, 4 SUB, 5 SHL, 6 SHR, 7 JUMP, 8 JGE, 9 LDA, 10 STA, 11 JZI, 12 LDI, 13 STI, 14 INCI, 15 JSR. Opcodes 16 to 31 change nothing except PC, which advances.
- R3: LOAD copies M[ea] into AC. STORE writes AC to M[ea]. ADD and SUB add M[ea] to AC or subtract it from AC, using 16-bit two's complement that wraps.
- R4: SHL shifts AC left by one bit, which doubles it and drops the top bit. SHR shifts AC right by one bit and keeps the sign.
- R5: JUMP loads ea into PC. JGE loads ea into PC only when AC bit 15 is 0; otherwise execution falls through.
- R6: LDA sets AC to bits [8:0] of M[ea], zero-extended. STA overwrites bits [8:0] of M[ea] with AC[8:0] and leaves bits [15:9] of that word unchanged.
- R7: When the index-select bit is 1, ea is (address field + IX) modulo 512. Otherwise ea is the address field.
- R8: When the indirect bit is 1, bits [8:0] of the word at the indexed address replace ea. This applies to both operand and jump instructions.
- R9: JZI branches to ea when IX is 0. Otherwise it adds 1 to IX (modulo 512) and falls through.
- R10: LDI loads IX from bits [8:0] of M[ea]. STI writes IX to M[ea], sign-extended to 16 bits. INCI adds its address field, read as a signed 9-bit value, to IX and ignores the index-select and indirect bits.
- R11: JSR writes its own address plus one, zero-extended, into M[ea] and continues at ea + 1.
- R12: After HLT, `halted` stays high and the core issues no memory write until reset. Instructions that follow the HLT are not executed.
- R13: Each store-type instruction (STORE, STA, STI, JSR) raises `mem_we` for exactly one cycle. No other instruction writes memory.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| mem_addr | output | 9 | Word address for the memory port |
| mem_we | output | 1 | Write strobe for the memory port |
| mem_wdata | output | 16 | Data to write to memory |
| mem_rdata | input | 16 | Read data, valid one cycle after its address |
| halted | output | 1 | High once HLT has executed |

## Verification
Two functions can land on the same operand: the index offset and the pointer indirection. The bench runs a LOAD with both bits set and a nonzero IX. It judges the result against M[M[x+IX]] and not against the other order, M[M[x]+IX]; the memory contents are laid out so that the two orders give different values. A second combination happens inside the counting branch, where the zero test and the increment share one instruction. That case is judged by running the indexed vector-add loop from IX = -n, checking that every element is summed exactly once, and checking that IX finishes at zero.

// File: rtl/acc_pkg.sv
package acc_pkg;
    localparam int WORD_W = 16;
    localparam int OP_W   = 5;
    localparam int ADDR_W = 9;
    localparam int EXT_W  = WORD_W - ADDR_W;

    typedef enum logic [OP_W-1:0] {
        OP_HLT  = 5'd0,  OP_LOAD = 5'd1,  OP_STORE = 5'd2,  OP_ADD = 5'd3,
        OP_SUB  = 5'd4,  OP_SHL  = 5'd5,  OP_SHR   = 5'd6,  OP_JUMP = 5'd7,
        OP_JGE  = 5'd8,  OP_LDA  = 5'd9,  OP_STA   = 5'd10, OP_JZI = 5'd11,
        OP_LDI  = 5'd12, OP_STI  = 5'd13, OP_INCI  = 5'd14, OP_JSR = 5'd15
    } op_e;

    typedef struct packed {
        op_e               op;
        logic              xb;
        logic              ib;
        logic [ADDR_W-1:0] addr;
    } instr_t;

    typedef enum logic [2:0] {
        S_FETCH, S_DECODE, S_IND_RD, S_IND_LD, S_OPFETCH, S_EXEC, S_WB, S_HALT
    } st_e;

    function automatic logic uses_ea(op_e op);
        case (op)
            OP_LOAD, OP_STORE, OP_ADD, OP_SUB, OP_JUMP, OP_JGE, OP_LDA,
            OP_STA, OP_JZI, OP_LDI, OP_STI, OP_JSR: return 1'b1;
            default: return 1'b0;
        endcase
    endfunction

    function automatic logic reads_opnd(op_e op);
        case (op)
            OP_LOAD, OP_ADD, OP_SUB, OP_LDA, OP_STA, OP_LDI: return 1'b1;
            default: return 1'b0;
        endcase
    endfunction

    function automatic logic writes_mem(op_e op);
        case (op)
            OP_STORE, OP_STA, OP_STI, OP_JSR: return 1'b1;
            default: return 1'b0;
        endcase
    endfunction
endpackage

// File: rtl/acc_agen.sv
module acc_agen
    import acc_pkg::*;
#(
    parameter int AW = ADDR_W
) (
    input  logic [AW-1:0] field,
    input  logic          xsel,
    input  logic [AW-1:0] ix,
    output logic [AW-1:0] ea
);
    always_comb begin
        ea = field + (xsel ? ix : '0);
    end
endmodule

// File: rtl/acc_fsm.sv
module acc_fsm
    import acc_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  op_e  cur_op,
    input  logic cur_ib,
    output st_e  state
);
    st_e nxt;

    always_comb begin
        nxt = state;
        case (state)
            S_FETCH:  nxt = S_DECODE;
            S_DECODE: begin
                if (cur_op == OP_HLT)                     nxt = S_HALT;
                else if (uses_ea(cur_op) && cur_ib)       nxt = S_IND_RD;
                else if (reads_opnd(cur_op))              nxt = S_OPFETCH;
                else                                      nxt = S_EXEC;
            end
            S_IND_RD:  nxt = S_IND_LD;
            S_IND_LD:  nxt = reads_opnd(cur_op) ? S_OPFETCH : S_EXEC;
            S_OPFETCH: nxt = S_EXEC;
            S_EXEC:    nxt = writes_mem(cur_op) ? S_WB : S_FETCH;
            S_WB:      nxt = S_FETCH;
            S_HALT:    nxt = S_HALT;
            default:   nxt = S_FETCH;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) state <= S_FETCH;
        else     state <= nxt;
    end

    // R13: a write-back cycle is always followed by a fresh fetch
    a_r13_wb_to_fetch: assert property (@(posedge clk) disable iff (rst)
        (state == S_WB) |=> (state == S_FETCH));

    // R12: the halt state is never left without reset
    a_r12_halt_sticky: assert property (@(posedge clk) disable iff (rst)
        (state == S_HALT) |=> (state == S_HALT));
endmodule

// File: rtl/acc_exec.sv
module acc_exec
    import acc_pkg::*;
(
    input  op_e               op,
    input  logic [ADDR_W-1:0] k,
    input  logic [WORD_W-1:0] ac,
    input  logic [ADDR_W-1:0] ix,
    input  logic [ADDR_W-1:0] pc,
    input  logic [ADDR_W-1:0] ea,
    input  logic [WORD_W-1:0] opnd,
    output logic [WORD_W-1:0] ac_n,
    output logic [ADDR_W-1:0] ix_n,
    output logic [ADDR_W-1:0] pc_n,
    output logic [WORD_W-1:0] wb_n
);
    always_comb begin
        ac_n = ac;
        ix_n = ix;
        pc_n = pc;
        wb_n = '0;
        case (op)
            OP_LOAD:  ac_n = opnd;
            OP_ADD:   ac_n = ac + opnd;
            OP_SUB:   ac_n = ac - opnd;
            OP_SHL:   ac_n = {ac[WORD_W-2:0], 1'b0};
            OP_SHR:   ac_n = {ac[WORD_W-1], ac[WORD_W-1:1]};
            OP_STORE: wb_n = ac;
            OP_JUMP:  pc_n = ea;
            OP_JGE:   if (!ac[WORD_W-1]) pc_n = ea;
            OP_LDA:   ac_n = {{EXT_W{1'b0}}, opnd[ADDR_W-1:0]};
            OP_STA:   wb_n = {opnd[WORD_W-1:ADDR_W], ac[ADDR_W-1:0]};
            OP_JZI: begin
                if (ix == '0) pc_n = ea;
                else          ix_n = ix + ADDR_W'(1);
            end
            OP_LDI:   ix_n = opnd[ADDR_W-1:0];
            OP_STI:   wb_n = {{EXT_W{ix[ADDR_W-1]}}, ix};
            OP_INCI:  ix_n = ix + k;
            OP_JSR: begin
                wb_n = {{EXT_W{1'b0}}, pc};
                pc_n = ea + ADDR_W'(1);
            end
            default: ;
        endcase
    end
endmodule

// File: rtl/acc_core.sv
module acc_core
    import acc_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    output logic [ADDR_W-1:0] mem_addr,
    output logic              mem_we,
    output logic [WORD_W-1:0] mem_wdata,
    input  logic [WORD_W-1:0] mem_rdata,
    output logic              halted
);
    st_e               state;
    instr_t            ir_q, cur_ir;
    logic [ADDR_W-1:0] pc_q, ix_q, ea_q, ea_base;
    logic [WORD_W-1:0] ac_q, wb_q;
    logic [WORD_W-1:0] ac_n, wb_n;
    logic [ADDR_W-1:0] ix_n, pc_n;

    assign cur_ir = (state == S_DECODE) ? instr_t'(mem_rdata) : ir_q;

    acc_fsm u_fsm (
        .clk    (clk),
        .rst    (rst),
        .cur_op (cur_ir.op),
        .cur_ib (cur_ir.ib),
        .state  (state)
    );

    acc_agen #(.AW(ADDR_W)) u_agen (
        .field (cur_ir.addr),
        .xsel  (cur_ir.xb),
        .ix    (ix_q),
        .ea    (ea_base)
    );

    acc_exec u_exec (
        .op   (cur_ir.op),
        .k    (cur_ir.addr),
        .ac   (ac_q),
        .ix   (ix_q),
        .pc   (pc_q),
        .ea   (ea_q),
        .opnd (mem_rdata),
        .ac_n (ac_n),
        .ix_n (ix_n),
        .pc_n (pc_n),
        .wb_n (wb_n)
    );

    always_comb begin
        case (state)
            S_IND_RD, S_OPFETCH, S_WB: mem_addr = ea_q;
            default:                   mem_addr = pc_q;
        endcase
    end
    assign mem_we    = (state == S_WB);
    assign mem_wdata = wb_q;
    assign halted    = (state == S_HALT);

    always_ff @(posedge clk) begin
        if (rst) begin
            pc_q <= '0;
            ac_q <= '0;
            ix_q <= '0;
            ea_q <= '0;
            wb_q <= '0;
            ir_q <= '0;
        end else begin
            case (state)
                S_DECODE: begin
                    ir_q <= cur_ir;
                    ea_q <= ea_base;
                    pc_q <= pc_q + ADDR_W'(1);
                end
                S_IND_LD: ea_q <= mem_rdata[ADDR_W-1:0];
                S_EXEC: begin
                    ac_q <= ac_n;
                    ix_q <= ix_n;
                    pc_q <= pc_n;
                    wb_q <= wb_n;
                end
                default: ;
            endcase
        end
    end

    // R1: reset leaves cleared architectural state and no halt
    a_r1_reset_clears: assert property (@(posedge clk)
        rst |=> (pc_q == '0 && ac_q == '0 && ix_q == '0 && !halted));

    // R12: halted is sticky and no write happens while halted
    a_r12_halt_holds: assert property (@(posedge clk) disable iff (rst)
        halted |=> halted);
    a_r12_no_write_halted: assert property (@(posedge clk) disable iff (rst)
        halted |-> !mem_we);

    // R13: a write strobe lasts a single cycle
    a_r13_single_write: assert property (@(posedge clk) disable iff (rst)
        mem_we |=> !mem_we);

    // R11: JSR writes the return address next cycle
    a_r11_jsr_return: assert property (@(posedge clk) disable iff (rst)
        (state == S_EXEC && ir_q.op == OP_JSR) |=>
        (mem_we && mem_wdata == {{EXT_W{1'b0}}, $past(pc_q)}));

    // R9: a failed zero test steps IX by one and leaves PC alone
    a_r9_jzi_step: assert property (@(posedge clk) disable iff (rst)
        (state == S_EXEC && ir_q.op == OP_JZI && ix_q != '0) |=>
        (ix_q == $past(ix_q) + ADDR_W'(1) && pc_q == $past(pc_q)));
endmodule

// File: tb/sim_acc_core.sv
`timescale 1ns/1ps
module sim_acc_core;
    import acc_pkg::*;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [8:0]  mem_addr;
    logic        mem_we;
    logic [15:0] mem_wdata;
    logic [15:0] mem_rdata;
    logic        halted;

    logic [15:0] mem [0:511];
    logic        clr = 1'b0, ld_en = 1'b0;
    logic [8:0]  ld_a = '0;
    logic [15:0] ld_d = '0;
    int          nchk = 0, nerr = 0, wcount = 0;

    always #2.5 clk = ~clk;

    acc_core u0 (
        .clk(clk), .rst(rst), .mem_addr(mem_addr), .mem_we(mem_we),
        .mem_wdata(mem_wdata), .mem_rdata(mem_rdata), .halted(halted)
    );

    always @(posedge clk) begin
        if (clr) begin
            for (int k = 0; k < 512; k++) mem[k] <= '0;
        end else if (ld_en) mem[ld_a] <= ld_d;
        else if (mem_we)    mem[mem_addr] <= mem_wdata;
        mem_rdata <= mem[mem_addr];
        if (!rst && mem_we) wcount <= wcount + 1;
    end

    function automatic logic [15:0] ins(logic [4:0] op, logic x, logic i, logic [8:0] a);
        return {op, x, i, a};
    endfunction

    task automatic chk(string req, logic [15:0] act, logic [15:0] exp);
        nchk++;
        if (act !== exp) begin
            nerr++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic hold_reset();
        @(negedge clk); rst = 1'b1;
        @(negedge clk); clr = 1'b1;
        @(negedge clk); clr = 1'b0;
    endtask

    task automatic poke(int a, logic [15:0] d);
        @(negedge clk); ld_en = 1'b1; ld_a = 9'(a); ld_d = d;
        @(negedge clk); ld_en = 1'b0;
    endtask

    task automatic run(string req);
        int n = 0;
        @(negedge clk); rst = 1'b0;
        while (!halted && n < 3000) begin
            @(negedge clk); n++;
        end
        nchk++;
        if (!halted) begin
            nerr++;
            $display("FAIL %s: actual no-halt expected halt", req);
        end
    endtask

    task automatic t_reset();
        hold_reset();
        poke(0, ins(OP_STORE, 0, 0, 30));
        poke(1, ins(OP_STI, 0, 0, 31));
        poke(2, ins(OP_HLT, 0, 0, 0));
        poke(30, 16'hFFFF); poke(31, 16'hFFFF);
        @(negedge clk); rst = 1'b0;
        chk("R1 addr", {7'd0, mem_addr}, 16'h0000);
        chk("R1 we", {15'd0, mem_we}, 16'h0000);
        chk("R1 halted", {15'd0, halted}, 16'h0000);
        @(negedge clk); rst = 1'b1;
        run("R1 run");
        chk("R1 ac cleared", mem[30], 16'h0000);
        chk("R1 ix cleared", mem[31], 16'h0000);
    endtask

    task automatic t_arith();
        int w0;
        hold_reset();
        poke(0, ins(OP_LOAD, 0, 0, 20)); poke(1, ins(OP_ADD, 0, 0, 21));
        poke(2, ins(OP_STORE, 0, 0, 30)); poke(3, 16'hFFFF);
        poke(4, ins(OP_SUB, 0, 0, 22)); poke(5, ins(OP_STORE, 0, 0, 31));
        poke(6, ins(OP_LOAD, 0, 0, 23)); poke(7, ins(OP_ADD, 0, 0, 24));
        poke(8, ins(OP_STORE, 0, 0, 32)); poke(9, ins(OP_HLT, 0, 0, 0));
        poke(20, 16'h0064); poke(21, 16'h0123); poke(22, 16'h0200);
        poke(23, 16'h7FFF); poke(24, 16'h0001);
        w0 = wcount;
        run("R3 run");
        chk("R3 add", mem[30], 16'h0064 + 16'h0123);
        chk("R2 undefined opcode no-op then R3 sub", mem[31], 16'h0187 - 16'h0200);
        chk("R3 wrap", mem[32], 16'h8000);
        chk("R13 write count", 16'(wcount - w0), 16'd3);
    endtask

    task automatic t_shift();
        hold_reset();
        poke(0, ins(OP_LOAD, 0, 0, 20)); poke(1, ins(OP_SHL, 0, 0, 0));
        poke(2, ins(OP_STORE, 0, 0, 30)); poke(3, ins(OP_SHR, 0, 0, 0));
        poke(4, ins(OP_STORE, 0, 0, 31)); poke(5, ins(OP_SHR, 0, 0, 0));
        poke(6, ins(OP_STORE, 0, 0, 32)); poke(7, ins(OP_LOAD, 0, 0, 21));
        poke(8, ins(OP_SHL, 0, 0, 0)); poke(9, ins(OP_STORE, 0, 0, 33));
        poke(10, ins(OP_HLT, 0, 0, 0));
        poke(20, 16'hC003); poke(21, 16'h4001);
        run("R4 run");
        chk("R4 shl", mem[30], 16'h8006);
        chk("R4 shr sign", mem[31], 16'hC003);
        chk("R4 shr again", mem[32], 16'hE001);
        chk("R4 shl drop msb", mem[33], 16'h8002);
    endtask

    task automatic t_jump();
        hold_reset();
        poke(0, ins(OP_LOAD, 0, 0, 20)); poke(1, ins(OP_JGE, 0, 0, 9));
        poke(2, ins(OP_LOAD, 0, 0, 21)); poke(3, ins(OP_STORE, 0, 0, 30));
        poke(4, ins(OP_LOAD, 0, 0, 22)); poke(5, ins(OP_JGE, 0, 0, 8));
        poke(6, ins(OP_LOAD, 0, 0, 21)); poke(7, ins(OP_STORE, 0, 0, 31));
        poke(8, ins(OP_LOAD, 0, 0, 23)); poke(9, ins(OP_JUMP, 0, 0, 12));
        poke(10, ins(OP_STORE, 0, 0, 32)); poke(11, ins(OP_HLT, 0, 0, 0));
        poke(12, ins(OP_STORE, 0, 0, 33)); poke(13, ins(OP_LOAD, 0, 0, 24));
        poke(14, ins(OP_JGE, 0, 0, 16)); poke(15, ins(OP_STORE, 0, 0, 34));
        poke(16, ins(OP_HLT, 0, 0, 0));
        poke(20, 16'hFFFF); poke(21, 16'h0011); poke(23, 16'h0022); poke(24, 16'h0005);
        run("R5 run");
        chk("R5 jge negative falls through", mem[30], 16'h0011);
        chk("R5 jge zero taken", mem[31], 16'h0000);
        chk("R5 jump skips", mem[32], 16'h0000);
        chk("R5 jump target", mem[33], 16'h0022);
        chk("R5 jge positive taken", mem[34], 16'h0000);
    endtask

    task automatic t_addr_field();
        hold_reset();
        poke(0, ins(OP_LDA, 0, 0, 20)); poke(1, ins(OP_STORE, 0, 0, 30));
        poke(2, ins(OP_LOAD, 0, 0, 21)); poke(3, ins(OP_STA, 0, 0, 22));
        poke(4, ins(OP_HLT, 0, 0, 0));
        poke(20, 16'hABCD); poke(21, 16'h1234); poke(22, 16'hFFFF);
        run("R6 run");
        chk("R6 lda", mem[30], 16'h01CD);
        chk("R6 sta", mem[22], 16'hFE34);
    endtask

    task automatic t_vector();
        logic [15:0] a [4] = '{16'h0001, 16'h7FFF, 16'hFFFE, 16'h1000};
        logic [15:0] b [4] = '{16'h0002, 16'h0001, 16'hFFFF, 16'h2345};
        hold_reset();
        poke(0, ins(OP_LDI, 0, 0, 20)); poke(1, ins(OP_JZI, 0, 0, 7));
        poke(2, ins(OP_LOAD, 1, 0, 43)); poke(3, ins(OP_ADD, 1, 0, 53));
        poke(4, ins(OP_STORE, 1, 0, 63)); poke(5, ins(OP_JUMP, 0, 0, 1));
        poke(6, ins(OP_HLT, 0, 0, 0)); poke(7, ins(OP_STI, 0, 0, 21));
        poke(8, ins(OP_HLT, 0, 0, 0));
        poke(20, 16'hFFFC); poke(21, 16'hAAAA);
        for (int k = 0; k < 4; k++) begin
            poke(40 + k, a[k]); poke(50 + k, b[k]);
        end
        run("R7 run");
        for (int k = 0; k < 4; k++)
            chk("R7 R9 vector element", mem[60 + k], a[k] + b[k]);
        chk("R9 R10 final IX", mem[21], 16'h0000);
    endtask

    task automatic t_indirect();
        hold_reset();
        poke(0, ins(OP_LDI, 0, 0, 20)); poke(1, ins(OP_LOAD, 1, 1, 30));
        poke(2, ins(OP_STORE, 0, 0, 100)); poke(3, ins(OP_LOAD, 0, 1, 31));
        poke(4, ins(OP_STORE, 0, 1, 33)); poke(5, ins(OP_JUMP, 0, 1, 34));
        poke(6, ins(OP_STORE, 0, 0, 101)); poke(7, ins(OP_HLT, 0, 0, 0));
        poke(9, ins(OP_LOAD, 0, 0, 35)); poke(10, ins(OP_STORE, 0, 0, 102));
        poke(11, ins(OP_HLT, 0, 0, 0));
        poke(20, 16'h0002); poke(30, 16'h0074); poke(32, 16'h0070);
        poke(31, 16'hFE71); poke(33, 16'h0072); poke(34, 16'h0009);
        poke(35, 16'h0444); poke(16'h70, 16'h5A5A); poke(16'h71, 16'h1357);
        poke(16'h76, 16'hDEAD);
        run("R8 run");
        chk("R7 R8 index then indirect", mem[100], 16'h5A5A);
        chk("R8 indirect store", mem[16'h72], 16'h1357);
        chk("R8 indirect jump skips", mem[101], 16'h0000);
        chk("R8 indirect jump target", mem[102], 16'h0444);
    endtask

    task automatic t_index_ops();
        hold_reset();
        poke(0, ins(OP_LDI, 0, 0, 20)); poke(1, ins(OP_INCI, 0, 0, 9'h1FB));
        poke(2, ins(OP_STI, 0, 0, 30)); poke(3, ins(OP_INCI, 1, 1, 9'h002));
        poke(4, ins(OP_STI, 0, 0, 31)); poke(5, ins(OP_LDI, 0, 0, 21));
        poke(6, ins(OP_STI, 0, 0, 32)); poke(7, ins(OP_JZI, 0, 0, 12));
        poke(8, ins(OP_STI, 0, 0, 33)); poke(9, ins(OP_INCI, 0, 0, 9'h10A));
        poke(10, ins(OP_JZI, 0, 0, 13)); poke(11, ins(OP_STI, 0, 0, 34));
        poke(12, ins(OP_HLT, 0, 0, 0)); poke(13, ins(OP_STI, 0, 0, 35));
        poke(14, ins(OP_HLT, 0, 0, 0));
        poke(20, 16'h0003); poke(21, 16'hF0F5);
        poke(31, 16'hAAAA); poke(34, 16'hAAAA); poke(35, 16'hAAAA);
        run("R10 run");
        chk("R10 inci negative, sti sign-extend", mem[30], 16'hFFFE);
        chk("R10 inci ignores x/i bits", mem[31], 16'h0000);
        chk("R10 ldi truncates", mem[32], 16'h00F5);
        chk("R9 jzi nonzero increments", mem[33], 16'h00F6);
        chk("R9 jzi zero taken skips", mem[34], 16'hAAAA);
        chk("R9 jzi zero target", mem[35], 16'h0000);
    endtask

    task automatic t_jsr();
        hold_reset();
        poke(0, ins(OP_LOAD, 0, 0, 20)); poke(1, ins(OP_JSR, 0, 0, 40));
        poke(2, ins(OP_LOAD, 0, 0, 21)); poke(3, ins(OP_STORE, 0, 0, 31));
        poke(4, ins(OP_HLT, 0, 0, 0));
        poke(41, ins(OP_STORE, 0, 0, 30)); poke(42, ins(OP_JUMP, 0, 1, 40));
        poke(20, 16'h0777); poke(21, 16'h0888);
        run("R11 run");
        chk("R11 return address", mem[40], 16'h0002);
        chk("R11 body at F+1", mem[30], 16'h0777);
        chk("R11 return path", mem[31], 16'h0888);
    endtask

    task automatic t_halt();
        int w0, bad;
        hold_reset();
        poke(0, ins(OP_LOAD, 0, 0, 20)); poke(1, ins(OP_HLT, 0, 0, 0));
        poke(2, ins(OP_STORE, 0, 0, 30)); poke(20, 16'h0001);
        run("R12 run");
        w0 = wcount; bad = 0;
        for (int k = 0; k < 20; k++) begin
            @(negedge clk);
            if (!halted || mem_we) bad++;
        end
        chk("R12 halt held, no write", 16'(bad), 16'd0);
        chk("R12 no writes counted", 16'(wcount - w0), 16'd0);
        chk("R12 after-halt store skipped", mem[30], 16'h0000);
        @(negedge clk); rst = 1'b1;
        @(negedge clk);
        chk("R1 reset clears halted", {15'd0, halted}, 16'h0000);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        nerr++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        t_reset();
        t_arith();
        t_shift();
        t_jump();
        t_addr_field();
        t_vector();
        t_indirect();
        t_index_ops();
        t_jsr();
        t_halt();
        $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
        $finish;
    end
endmodule